// File: doc/BRIEF.md
# SPI Register-Access Slave with Odd Parity

This block is the protocol engine of a four-wire SPI slave. All traffic is carried in 16-bit words. Bits D15:D1 hold the payload and D0 holds a parity bit chosen so that every complete word has an odd number of ones. The master opens a frame by pulling chip-select low. The first word it sends is an address word: D15:D9 hold a 7-bit register address, D8 is the access flag (1 = write, 0 = read), and D7:D1 are zero. While that first word is shifting in, the slave returns its status word on MISO.

The access flag of the previous word decides what the next word means. After a read address, the slave shifts out the selected register during the next word, and the master's word in that slot is taken as a new address. After a write address, the next MOSI word is data. Its 15-bit payload is stored in the register, and the register's previous contents go out on MISO in the same slot. After a data word, the engine expects an address again and sends status. Reads and writes may be mixed freely while chip-select stays low. Raising chip-select ends the frame at any point.

The SPI pins are sampled in the system clock domain through a short synchronizer, so SCLK has to run several times slower than the system clock. Operation is SPI mode 0, MSB first. MOSI is taken on rising SCLK and MISO changes on falling SCLK. There is no stream payload to buffer, so the pins have no valid/ready handshake. The master paces every transfer with SCLK and chip-select.

Top module: `spi_reg_slave`

## Requirements
- R1: Every 16-bit word the slave puts on MISO has odd parity overall, with its parity bit in D0.
- R2: The status word has D15:D7 zero, D6:D3 = mon_fault[3:0], D2 = sticky parity error and D1 = OK. OK is 1 exactly when D6:D2 are all zero. It is sent during the first word of a frame and after every data word. It reflects the flags that result from the word just completed.
- R3: After a good-parity address word with D8=0, the next MISO word is the addressed register, and the next MOSI word is decoded as a new address.
- R4: After a good-parity address word with D8=1, the next MOSI word is data. Its D15:D1 are stored into the addressed register, and during that word MISO carries the register's value from before the write.
- R5: After a data word, the next MOSI word is decoded as an address. Reads and writes may therefore alternate within one chip-select-low frame.
- R6: Addresses 0..3 are read/write registers and address 08h reads the status word. Every other address reads as a zero payload and ignores writes.
- R7: A data word with bad parity changes no register and sets the sticky parity-error flag. The engine then returns to the address phase.
- R8: An address word with bad parity starts no access and sets the sticky parity-error flag. The next MISO word is status and the next MOSI word is an address.
- R9: Raising chip-select mid-word discards the partial word. MISO is 0 while chip-select is high, and the next frame starts in the address phase with a status word.
- R10: A good-parity write to address 08h clears the sticky parity-error flag. The other status bits are not writable.
- R11: After reset, all read/write registers are zero and the parity-error flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master |
| csn | input | 1 | Active-low chip-select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 while deselected |
| mon_fault | input | MON_W | Monitoring fault flags shown in the status word |

## Verification
The bench drives whole frames that mix reads and writes: write-then-read on one register, back-to-back writes that show the old value echoed, and reads of every register after alternating-bit patterns. These tell the read, write and echo paths apart and expose any wrong phase tracking. Accesses to unmapped addresses and to the status address separate the mapped, status and empty decode paths. Words with corrupted parity in the address slot and in the data slot check the two different recovery paths. A frame cut off after seven bits shows whether the engine discards a partial word or keeps it.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int WORD_W = 16;
  localparam int PAY_W  = WORD_W - 1;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  // parity bit that gives the whole word an odd number of ones
  function automatic logic odd_fill(input logic [PAY_W-1:0] pay);
    return ~(^pay);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csn,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s,
  output logic cs_idle,
  output logic cs_start
);
  logic [STAGES-1:0] sck_sr, cs_sr, mo_sr;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      mo_sr  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        sck_sr[i] <= sck_sr[i-1];
        cs_sr[i]  <= cs_sr[i-1];
        mo_sr[i]  <= mo_sr[i-1];
      end
      sck_sr[0] <= sclk;
      cs_sr[0]  <= csn;
      mo_sr[0]  <= mosi;
      sck_d     <= sck_sr[STAGES-1];
      cs_d      <= cs_sr[STAGES-1];
    end
  end

  assign cs_idle   = cs_sr[STAGES-1];
  assign cs_start  = cs_d & ~cs_sr[STAGES-1];
  assign sclk_rise = sck_sr[STAGES-1] & ~sck_d & ~cs_idle;
  assign sclk_fall = ~sck_sr[STAGES-1] & sck_d & ~cs_idle;
  assign mosi_s    = mo_sr[STAGES-1];
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int WORD_W = spi_reg_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              miso
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] rx_sr;
  logic [WORD_W-1:0] tx_sr;
  logic [CNT_W-1:0]  bit_cnt;

  assign word_done = sclk_rise & (bit_cnt == LAST);
  assign rx_word   = {rx_sr[WORD_W-2:0], mosi_s};
  assign miso      = tx_sr[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr   <= '0;
      bit_cnt <= '0;
    end else if (cs_idle) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      rx_sr   <= rx_word;
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
    end
  end

  // a fresh word is loaded after the last rising edge; the falling edge
  // that follows it must not shift, hence the count guard
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (cs_idle) begin
      tx_sr <= '0;
    end else if (tx_load) begin
      tx_sr <= tx_word;
    end else if (sclk_fall && bit_cnt != '0) begin
      tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int NUM_RW      = 4,
  parameter int ADDR_W      = 7,
  parameter int PAY_W       = spi_reg_pkg::PAY_W,
  parameter int STATUS_ADDR = 8,
  parameter int MON_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PAY_W-1:0]  wr_data,
  input  logic              perr_set,
  input  logic [MON_W-1:0]  mon_fault,
  output logic [PAY_W-1:0]  rd_data,
  output logic [PAY_W-1:0]  status_word
);
  localparam int IDX_W = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;
  localparam logic [ADDR_W-1:0] ST_A  = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] RW_LIM = ADDR_W'(NUM_RW);

  logic [PAY_W-1:0] regs [NUM_RW];
  logic perr_q, perr_clr, perr_eff;

  assign perr_clr = wr_en && (wr_addr == ST_A);
  assign perr_eff = perr_set | (perr_q & ~perr_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
    end else if (perr_set) begin
      perr_q <= 1'b1;
    end else if (perr_clr) begin
      perr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RW; i++) regs[i] <= '0;
    end else if (wr_en && wr_addr < RW_LIM) begin
      regs[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  always_comb begin
    status_word = '0;
    status_word[MON_W+1:2] = mon_fault;
    status_word[1] = perr_eff;
    status_word[0] = ~(|mon_fault | perr_eff);
  end

  always_comb begin
    if (rd_addr == ST_A)        rd_data = status_word;
    else if (rd_addr < RW_LIM)  rd_data = regs[rd_addr[IDX_W-1:0]];
    else                        rd_data = '0;
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int NUM_RW      = 4,
  parameter int ADDR_W      = 7,
  parameter int STATUS_ADDR = 8,
  parameter int MON_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             csn,
  input  logic             mosi,
  output logic             miso,
  input  logic [MON_W-1:0] mon_fault
);
  import spi_reg_pkg::*;

  localparam int RW_POS = WORD_W - 1 - ADDR_W;

  logic sclk_rise, sclk_fall, mosi_s, cs_idle, cs_start;
  logic word_done, tx_load;
  logic [WORD_W-1:0] rx_word, tx_word;
  logic [PAY_W-1:0]  tx_pay, rd_data, status_word;
  logic [ADDR_W-1:0] adr_f, addr_q;
  logic rw_f, par_ok, wr_en, perr_set;
  phase_t phase, phase_n;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .cs_idle(cs_idle), .cs_start(cs_start)
  );

  spi_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .tx_load(tx_load), .tx_word(tx_word),
    .word_done(word_done), .rx_word(rx_word), .miso(miso)
  );

  spi_reg_bank #(
    .NUM_RW(NUM_RW), .ADDR_W(ADDR_W), .PAY_W(PAY_W),
    .STATUS_ADDR(STATUS_ADDR), .MON_W(MON_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .rd_addr(adr_f),
    .wr_en(wr_en), .wr_addr(addr_q), .wr_data(rx_word[WORD_W-1:1]),
    .perr_set(perr_set), .mon_fault(mon_fault),
    .rd_data(rd_data), .status_word(status_word)
  );

  assign adr_f   = rx_word[WORD_W-1 -: ADDR_W];
  assign rw_f    = rx_word[RW_POS];
  assign par_ok  = ^rx_word;
  assign tx_load = cs_start | word_done;
  assign tx_word = {tx_pay, odd_fill(tx_pay)};

  // word-phase decision: what the finished word meant, what goes out next
  always_comb begin
    wr_en    = 1'b0;
    perr_set = 1'b0;
    tx_pay   = status_word;
    phase_n  = phase;
    if (word_done) begin
      if (phase == PH_ADDR) begin
        if (!par_ok) begin
          perr_set = 1'b1;
        end else begin
          tx_pay = rd_data;
          if (rw_f) phase_n = PH_DATA;
        end
      end else begin
        if (par_ok) wr_en = 1'b1;
        else        perr_set = 1'b1;
        phase_n = PH_ADDR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_ADDR;
      addr_q <= '0;
    end else if (cs_idle) begin
      phase  <= PH_ADDR;
    end else begin
      phase <= phase_n;
      if (word_done && phase == PH_ADDR && par_ok) addr_q <= adr_f;
    end
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_idle,
  input logic                 word_done,
  input logic [15:0]          rx_word,
  input spi_reg_pkg::phase_t  phase,
  input logic                 tx_load,
  input logic [15:0]          tx_word,
  input logic                 miso,
  input logic                 wr_en
);
  import spi_reg_pkg::*;

  a_r1_tx_odd: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (^tx_word) == 1'b1);

  a_r9_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_idle && $past(cs_idle)) |-> !miso);

  a_r9_idle_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> phase == PH_ADDR);

  a_r4_write_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && phase == PH_ADDR && (^rx_word) && rx_word[8]) |=> phase == PH_DATA);

  a_r3_read_stays_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && phase == PH_ADDR && !rx_word[8]) |=> phase == PH_ADDR);

  a_r5_data_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && phase == PH_DATA) |=> phase == PH_ADDR);

  a_r7_bad_par_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !(^rx_word)) |-> !wr_en);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .word_done(word_done),
  .rx_word(rx_word), .phase(phase), .tx_load(tx_load), .tx_word(tx_word),
  .miso(miso), .wr_en(wr_en)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;
  logic clk = 1'b0;
  logic rst_n, sclk, csn, mosi;
  logic miso;
  logic [3:0] mon;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [14:0] mregs [4];
  bit mperr;
  bit mdata;
  int maddr;
  logic [15:0] exp_tx;

  always #10 clk = ~clk;

  spi_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .mosi(mosi),
    .miso(miso), .mon_fault(mon)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired at %0d cycles (expected done)", cycles);
      finished = 1'b1;
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [14:0] p);
    return {p, ~(^p)};
  endfunction

  function automatic logic [15:0] adw(input int a, input bit wr);
    return mk({a[6:0], wr, 7'b0});
  endfunction

  function automatic logic [14:0] mstatus();
    return {9'b0, mon, mperr, ~(|mon | mperr)};
  endfunction

  function automatic logic [14:0] mread(input int a);
    if (a == 8) return mstatus();
    if (a < 4)  return mregs[a];
    return 15'h0;
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin();
    csn = 1'b0;
    mdata = 1'b0;
    exp_tx = mk(mstatus());
    ticks(6);
  endtask

  task automatic frame_end();
    ticks(6);
    csn = 1'b1;
    ticks(10);
    check(miso == 1'b0, "R9 miso idle", {15'b0, miso}, 16'h0);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n, output logic [15:0] got);
    got = '0;
    for (int i = 15; i > 15 - n; i--) begin
      mosi = w[i];
      ticks(6);
      got[i] = miso;
      sclk = 1'b1;
      ticks(6);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [15:0] w, input string tag);
    logic [15:0] got;
    int a;
    shift_bits(w, 16, got);
    check(got == exp_tx, tag, got, exp_tx);
    check((^got) == 1'b1, "R1 miso parity", got, exp_tx);
    if (!mdata) begin
      if (!(^w)) begin
        mperr = 1'b1;
        exp_tx = mk(mstatus());
      end else begin
        a = int'(w[15:9]);
        exp_tx = mk(mread(a));
        maddr = a;
        if (w[8]) mdata = 1'b1;
      end
    end else begin
      if (^w) begin
        if (maddr < 4) mregs[maddr] = w[15:1];
        else if (maddr == 8) mperr = 1'b0;
      end else begin
        mperr = 1'b1;
      end
      exp_tx = mk(mstatus());
      mdata = 1'b0;
    end
  endtask

  initial begin
    logic [15:0] junk;
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0; mon = 4'h0;
    for (int i = 0; i < 4; i++) mregs[i] = 15'h0;
    mperr = 1'b0; mdata = 1'b0; maddr = 0;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);
    check(miso == 1'b0, "R11 reset miso", {15'b0, miso}, 16'h0);

    // R11/R2: status at frame start, registers zero after reset
    frame_begin();
    xfer(adw(0, 0), "R2 R11 status at frame start");
    xfer(adw(3, 0), "R11 reg0 after reset");
    xfer(adw(0, 0), "R11 reg3 after reset");
    frame_end();

    // R4/R5: mixed frame with write, echo of old value, then reads
    frame_begin();
    xfer(adw(1, 1), "R2 status before write");
    xfer(mk(15'h1234), "R4 old value echoed");
    xfer(adw(1, 0), "R5 status after data word");
    xfer(adw(2, 1), "R3 read of reg1");
    xfer(mk(15'h5555), "R4 reg2 old value");
    xfer(adw(2, 1), "R5 status after data");
    xfer(mk(15'h2AAA), "R4 second write echoes first");
    xfer(adw(3, 1), "R5 status again");
    xfer(mk(15'h7FFF), "R4 reg3 old value");
    xfer(adw(0, 0), "R5 back to address");
    frame_end();

    // R3: reads of every register, the slot after a read is an address
    frame_begin();
    for (int a = 0; a < 4; a++) xfer(adw(a, 0), "R3 read chain");
    xfer(adw(8, 0), "R3 last register");
    xfer(adw(0, 0), "R3 status via address 08h");
    frame_end();

    // R6: unmapped addresses read zero and ignore writes
    frame_begin();
    xfer(adw(5, 0), "R2 status");
    xfer(adw(7'h40, 1), "R6 read of address 5");
    xfer(mk(15'h0F0F), "R6 unmapped old value");
    xfer(adw(7'h40, 0), "R6 status");
    xfer(adw(7'h7F, 0), "R6 address 40h after write");
    xfer(adw(0, 0), "R6 address 7Fh");
    frame_end();

    // R2: monitoring flags drop OK
    mon = 4'b0101;
    ticks(4);
    frame_begin();
    xfer(adw(8, 0), "R2 status with faults");
    xfer(adw(0, 0), "R2 status read at 08h");
    frame_end();
    mon = 4'h0;
    ticks(4);

    // R7: bad parity data word is not stored, flag set
    frame_begin();
    xfer(adw(1, 1), "R2 status clean");
    xfer(mk(15'h0ABC) ^ 16'h0001, "R7 echo before bad data");
    xfer(adw(1, 0), "R7 status shows parity error");
    xfer(adw(0, 0), "R7 reg1 unchanged");
    frame_end();

    // R10: write to 08h clears the sticky flag
    frame_begin();
    xfer(adw(8, 1), "R7 sticky across frames");
    xfer(mk(15'h7FFF), "R10 status echoed");
    xfer(adw(8, 0), "R10 flag cleared");
    xfer(adw(0, 0), "R10 status read clean");
    frame_end();

    // R8: bad parity address word
    frame_begin();
    xfer(adw(2, 1) ^ 16'h0001, "R2 status");
    xfer(mk(15'h1111), "R8 status after bad address");
    xfer(adw(2, 0), "R8 data slot decoded as address");
    xfer(adw(0, 0), "R8 reg2 unchanged");
    frame_end();
    frame_begin();
    xfer(adw(8, 1), "R8 status");
    xfer(mk(15'h0), "R10 clear");
    xfer(adw(0, 0), "R10 clean");
    frame_end();

    // R9: partial word discarded on chip-select rise
    frame_begin();
    shift_bits(adw(0, 1), 7, junk);
    ticks(6);
    csn = 1'b1;
    ticks(10);
    check(miso == 1'b0, "R9 miso after abort", {15'b0, miso}, 16'h0);
    frame_begin();
    xfer(adw(0, 1), "R9 new frame starts with status");
    xfer(mk(15'h0042), "R9 reg0 echo");
    xfer(adw(0, 0), "R9 status");
    xfer(adw(0, 0), "R9 reg0 written");
    frame_end();

    finished = 1'b1;
    summary();
  end
endmodule